// File: doc/BRIEF.md
# SDRAM Write Burst Termination Sequencer

This block sits in the write path of an SDRAM controller and decides how a write burst ends. Each request names a bank, a start column, a burst length (two, four, eight beats or a whole page), an optional count of wanted beats, an auto-precharge flag and an action to take afterwards: a READ, a PRECHARGE of the same bank, or nothing. The sequencer puts the WRITE on the command bus, passes write data through while beats are wanted, and then ends the burst in the chosen way. A termination input, raised during a beat, makes that beat the last one and overrides the queued action.

When the burst ends with a READ, the READ follows the last wanted beat with no idle cycle, and the data path stops driving at once. When it ends with a PRECHARGE, the sequencer waits for write recovery, masks the data pins with DQM until the PRECHARGE is on the bus, and then starts a per-bank recovery counter. A device-variant input moves the PRECHARGE one clock later. A bank whose counter is running does not accept a new write.

Top module: `wr_term_seq`

## Requirements
- R1: After reset the command bus carries NOP (0111 on chip-select, row strobe, column strobe, write enable), DQM and data drive are low, busy is low and every bank reports ready.
- R2: A request accepted in cycle t (idle, request valid, its bank ready) puts WRITE (0100) on the bus in cycle t+1 with the request bank, and the address carries the column in its low bits and the auto-precharge flag in bit 10.
- R3: Data drive is high and the data output equals the write data input for N cycles starting with the WRITE cycle; length code 0, 1, 2 gives 2, 4, 8 beats, and a nonzero wanted-beat count C gives N = min(C, length).
- R4: With a READ ending (follow code 1, or term_rd during a beat), READ (0101) appears in the cycle right after the last beat, on the same bank, with the read column on the address, and data drive is low from that cycle on.
- R5: With a PRECHARGE ending (follow code 2, or term_pre during a beat) and auto-precharge clear, PRECHARGE (0010) with address bit 10 low appears TWR+1 cycles after the last beat, or TWR+2 when the variant input is high, with NOP in between.
- R6: DQM is low during wanted beats and high from the cycle after the last beat through the PRECHARGE cycle inclusive, so it is high on both the cycle before and the cycle of the PRECHARGE.
- R7: After a PRECHARGE in cycle P, that bank reports not ready in cycles P+1 through P+TRP and ready from P+TRP+1; a request to a bank that is not ready is ignored.
- R8: When auto-precharge is set, a PRECHARGE ending (queued or by term_pre) is dropped, no PRECHARGE is issued, and the bank reports not ready for max(TWR,1)+TRP cycles after the last beat.
- R9: A page-length write (length code 3) with no wanted-beat count keeps beating until term_rd or term_pre is seen in a beat cycle, which makes that cycle the last beat; with a count it stops after that many beats.
- R10: NOP is driven in every cycle with no command, and a request arriving while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| late_pre | input | 1 | Device variant: 1 places PRECHARGE one clock later |
| req_valid | input | 1 | Write request strobe |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Start column |
| req_len | input | 2 | Length code: 0=2, 1=4, 2=8, 3=page |
| req_stop | input | COL_W+1 | Wanted beat count, 0 = whole length |
| req_follow | input | 2 | Ending: 0 none, 1 read, 2 precharge |
| req_ap | input | 1 | Auto-precharge flag |
| req_rd_col | input | COL_W | Column for the follow-on READ |
| term_rd | input | 1 | End burst now with a READ |
| term_pre | input | 1 | End burst now with a PRECHARGE |
| wdata_in | input | DQ_W | Write data for the current beat |
| cmd_o | output | 4 | Chip-select, row strobe, column strobe, write enable |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| dq_o | output | DQ_W | Write data out |
| dq_oe_o | output | 1 | Data drive enable |
| dqm_o | output | 1 | Data mask |
| busy_o | output | 1 | Sequencer not idle |
| bank_rdy_o | output | NB | Per-bank ready flags |

## Verification
The WRITE is due one cycle after the accepting edge, each beat in the same cycle its data is presented, the READ one cycle after the last beat and the PRECHARGE TWR+1 (or TWR+2) cycles after it; bank ready drops the cycle after the PRECHARGE and returns TRP cycles later. The bench drives every input just after a falling edge and samples one nanosecond later, so each expected value is compared in the exact cycle the count above gives, with cycle 0 defined as the WRITE cycle. A sweep over lengths, wanted counts, endings, auto-precharge and variant settings, plus page-length and termination cases, computes all these cycle numbers arithmetically per case.

// File: rtl/wts_pkg.sv
`timescale 1ns/1ps
package wts_pkg;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_RD   = 2'd2,
    ST_GAP  = 2'd3
  } st_e;

  typedef enum logic [1:0] {
    FOL_NONE = 2'd0,
    FOL_READ = 2'd1,
    FOL_PRE  = 2'd2
  } follow_e;

  // beats in a burst for a length code
  function automatic int unsigned burst_beats(input logic [1:0] len, input int unsigned colw);
    case (len)
      2'd0:    return 2;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 32'd1 << colw;
    endcase
  endfunction

  // wanted beats; zero means open-ended (page with no count)
  function automatic int unsigned beats_wanted(input logic [1:0] len, input int unsigned stop,
                                               input int unsigned colw);
    int unsigned bl;
    bl = burst_beats(len, colw);
    if (stop == 0) return (len == 2'd3) ? 0 : bl;
    return (stop < bl) ? stop : bl;
  endfunction

  // idle cycles between last beat and precharge, exclusive of both
  function automatic int unsigned pre_gap(input int unsigned twr, input logic late);
    return twr + (late ? 32'd1 : 32'd0);
  endfunction

  // bank hold after an auto-precharged burst; recovery never below one clock
  function automatic int unsigned ap_hold(input int unsigned twr, input int unsigned trp);
    return ((twr == 0) ? 32'd1 : twr) + trp;
  endfunction

endpackage

// File: rtl/wts_bank_timers.sv
`timescale 1ns/1ps
module wts_bank_timers #(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BA_W-1:0]  load_bank,
  input  logic [TMR_W-1:0] load_val,
  output logic [NB-1:0]    bank_rdy
);

  for (genvar gi = 0; gi < NB; gi++) begin : g_bank
    logic [TMR_W-1:0] cnt;
    logic             hit;

    assign hit = load && (load_bank == BA_W'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (hit)            cnt <= load_val;
      else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign bank_rdy[gi] = (cnt == '0);

    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt == '0)) else $error("reload of counting bank"); // R7
    AST_RDY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && cnt == TMR_W'(1)) |=> bank_rdy[gi]) else $error("bank stuck"); // R7
  end

endmodule

// File: rtl/wts_burst_fsm.sv
`timescale 1ns/1ps
module wts_burst_fsm
  import wts_pkg::*;
#(
  parameter int NB    = 4,
  parameter int BA_W  = 2,
  parameter int COL_W = 8,
  parameter int TWR   = 2,
  parameter int TRP   = 3,
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             late_pre,
  input  logic             req_valid,
  input  logic [BA_W-1:0]  req_bank,
  input  logic [COL_W-1:0] req_col,
  input  logic [1:0]       req_len,
  input  logic [COL_W:0]   req_stop,
  input  logic [1:0]       req_follow,
  input  logic             req_ap,
  input  logic [COL_W-1:0] req_rd_col,
  input  logic             term_rd,
  input  logic             term_pre,
  input  logic [NB-1:0]    bank_rdy,
  output st_e              st_q,
  output logic             first_q,
  output logic [TMR_W-1:0] wait_q,
  output logic [BA_W-1:0]  bank_q,
  output logic [COL_W-1:0] col_q,
  output logic [COL_W-1:0] rdcol_q,
  output logic             ap_q,
  output logic             accept,
  output logic             last_beat,
  output logic             tmr_load,
  output logic [BA_W-1:0]  tmr_bank,
  output logic [TMR_W-1:0] tmr_val
);

  localparam int CW1 = COL_W + 1;

  logic [COL_W-1:0] beat_q;
  logic [CW1-1:0]   want_q;
  follow_e          fol_q;
  follow_e          fol_d;
  follow_e          act;
  logic             late_q;
  logic             hit_len;
  logic             pre_now;

  always_comb begin
    accept  = (st_q == ST_IDLE) && req_valid && bank_rdy[req_bank];
    if (req_follow == 2'd1)                fol_d = FOL_READ;
    else if (req_follow == 2'd2 && !req_ap) fol_d = FOL_PRE;
    else                                   fol_d = FOL_NONE;
    hit_len   = (want_q != '0) && ({1'b0, beat_q} == want_q - CW1'(1));
    last_beat = (st_q == ST_BEAT) && (hit_len || term_rd || term_pre);
    if (term_rd)       act = FOL_READ;
    else if (term_pre) act = ap_q ? FOL_NONE : FOL_PRE;
    else               act = fol_q;
    pre_now  = (st_q == ST_GAP) && (wait_q == '0);
    tmr_load = pre_now || (last_beat && act == FOL_NONE && ap_q);
    tmr_bank = bank_q;
    tmr_val  = pre_now ? TMR_W'(TRP) : TMR_W'(ap_hold(TWR, TRP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      beat_q  <= '0;
      want_q  <= '0;
      fol_q   <= FOL_NONE;
      late_q  <= 1'b0;
      wait_q  <= '0;
      bank_q  <= '0;
      col_q   <= '0;
      rdcol_q <= '0;
      ap_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q    <= ST_BEAT;
            first_q <= 1'b1;
            beat_q  <= '0;
            bank_q  <= req_bank;
            col_q   <= req_col;
            rdcol_q <= req_rd_col;
            ap_q    <= req_ap;
            late_q  <= late_pre;
            fol_q   <= fol_d;
            want_q  <= CW1'(beats_wanted(req_len, 32'(req_stop), COL_W));
          end
        end
        ST_BEAT: begin
          first_q <= 1'b0;
          beat_q  <= beat_q + 1'b1;
          if (last_beat) begin
            unique case (act)
              FOL_READ: st_q <= ST_RD;
              FOL_PRE: begin
                st_q   <= ST_GAP;
                wait_q <= TMR_W'(pre_gap(TWR, late_q));
              end
              default: st_q <= ST_IDLE;
            endcase
          end
        end
        ST_RD: st_q <= ST_IDLE;
        ST_GAP: begin
          if (wait_q == '0) st_q <= ST_IDLE;
          else              wait_q <= wait_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_AP_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP) |-> !ap_q) else $error("precharge wait with auto precharge"); // R8
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BEAT && !last_beat) |=> (st_q == ST_BEAT && !first_q)) else $error("burst restarted"); // R10

endmodule

// File: rtl/wts_cmd_drive.sv
`timescale 1ns/1ps
module wts_cmd_drive
  import wts_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DQ_W   = 16,
  parameter int TMR_W  = 4
) (
  input  st_e              st_q,
  input  logic             first_q,
  input  logic [TMR_W-1:0] wait_q,
  input  logic [BA_W-1:0]  bank_q,
  input  logic [COL_W-1:0] col_q,
  input  logic [COL_W-1:0] rdcol_q,
  input  logic             ap_q,
  input  logic [DQ_W-1:0]  wdata_in,
  output logic [3:0]       cmd,
  output logic [BA_W-1:0]  ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQ_W-1:0]  dq,
  output logic             dq_oe,
  output logic             dqm
);

  always_comb begin
    cmd   = CMD_NOP;
    ba    = bank_q;
    addr  = '0;
    dq    = '0;
    dq_oe = 1'b0;
    dqm   = 1'b0;
    unique case (st_q)
      ST_BEAT: begin
        dq_oe = 1'b1;
        dq    = wdata_in;
        if (first_q) begin
          cmd  = CMD_WR;
          addr = ADDR_W'(col_q) | (ADDR_W'(ap_q) << AP_BIT);
        end
      end
      ST_RD: begin
        cmd  = CMD_RD;
        addr = ADDR_W'(rdcol_q);
      end
      ST_GAP: begin
        dqm = 1'b1;
        if (wait_q == '0) cmd = CMD_PRE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wr_term_seq.sv
`timescale 1ns/1ps
module wr_term_seq
  import wts_pkg::*;
#(
  parameter int NB     = 4,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DQ_W   = 16,
  parameter int TWR    = 2,
  parameter int TRP    = 3,
  localparam int BA_W  = (NB > 1) ? $clog2(NB) : 1,
  localparam int TMR_W = $clog2(TWR + TRP + 3) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              late_pre,
  input  logic              req_valid,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [1:0]        req_len,
  input  logic [COL_W:0]    req_stop,
  input  logic [1:0]        req_follow,
  input  logic              req_ap,
  input  logic [COL_W-1:0]  req_rd_col,
  input  logic              term_rd,
  input  logic              term_pre,
  input  logic [DQ_W-1:0]   wdata_in,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              dqm_o,
  output logic              busy_o,
  output logic [NB-1:0]     bank_rdy_o
);

  st_e              st_q;
  logic             first_q;
  logic [TMR_W-1:0] wait_q;
  logic [BA_W-1:0]  bank_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] rdcol_q;
  logic             ap_q;
  logic             accept_ev;
  logic             last_beat_ev;
  logic             tmr_load;
  logic [BA_W-1:0]  tmr_bank;
  logic [TMR_W-1:0] tmr_val;
  logic             pre_issue_ev;
  logic             rd_issue_ev;

  wts_burst_fsm #(
    .NB(NB), .BA_W(BA_W), .COL_W(COL_W), .TWR(TWR), .TRP(TRP), .TMR_W(TMR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .late_pre(late_pre),
    .req_valid(req_valid), .req_bank(req_bank), .req_col(req_col),
    .req_len(req_len), .req_stop(req_stop), .req_follow(req_follow),
    .req_ap(req_ap), .req_rd_col(req_rd_col),
    .term_rd(term_rd), .term_pre(term_pre), .bank_rdy(bank_rdy_o),
    .st_q(st_q), .first_q(first_q), .wait_q(wait_q), .bank_q(bank_q),
    .col_q(col_q), .rdcol_q(rdcol_q), .ap_q(ap_q),
    .accept(accept_ev), .last_beat(last_beat_ev),
    .tmr_load(tmr_load), .tmr_bank(tmr_bank), .tmr_val(tmr_val)
  );

  wts_cmd_drive #(
    .BA_W(BA_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
    .DQ_W(DQ_W), .TMR_W(TMR_W)
  ) u_drv (
    .st_q(st_q), .first_q(first_q), .wait_q(wait_q), .bank_q(bank_q),
    .col_q(col_q), .rdcol_q(rdcol_q), .ap_q(ap_q), .wdata_in(wdata_in),
    .cmd(cmd_o), .ba(ba_o), .addr(addr_o), .dq(dq_o),
    .dq_oe(dq_oe_o), .dqm(dqm_o)
  );

  wts_bank_timers #(
    .NB(NB), .BA_W(BA_W), .TMR_W(TMR_W)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_bank(tmr_bank),
    .load_val(tmr_val), .bank_rdy(bank_rdy_o)
  );

  assign busy_o       = (st_q != ST_IDLE);
  assign pre_issue_ev = (cmd_o == CMD_PRE);
  assign rd_issue_ev  = (cmd_o == CMD_RD);

  AST_PRE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    pre_issue_ev |-> (dqm_o && $past(dqm_o))) else $error("unmasked precharge"); // R6
  AST_PRE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pre_issue_ev |-> (!dq_oe_o && !$past(dq_oe_o))) else $error("precharge too early"); // R5
  AST_RD_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue_ev |-> (!dq_oe_o && $past(dq_oe_o))) else $error("read not adjacent"); // R4
  AST_WR_BANK_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_WR) |-> bank_rdy_o[ba_o]) else $error("write to recovering bank"); // R7
  AST_BEAT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_o |-> !dqm_o) else $error("wanted beat masked"); // R6
  AST_PRE_LOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_issue_ev && TRP > 0) |=> !bank_rdy_o[$past(ba_o)]) else $error("no recovery hold"); // R7

endmodule

// File: tb/wr_term_seq_tb.sv
`timescale 1ns/1ps
module wr_term_seq_tb;

  localparam int NB = 4, BA_W = 2, COL_W = 8, ADDR_W = 13, DQ_W = 16;
  localparam int TWR = 2, TRP = 3;
  localparam logic [3:0] E_NOP = 4'b0111, E_RD = 4'b0101, E_WR = 4'b0100, E_PRE = 4'b0010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic late_pre = 1'b0, req_valid = 1'b0, req_ap = 1'b0, term_rd = 1'b0, term_pre = 1'b0;
  logic [BA_W-1:0] req_bank = '0;
  logic [COL_W-1:0] req_col = '0, req_rd_col = '0;
  logic [1:0] req_len = '0, req_follow = '0;
  logic [COL_W:0] req_stop = '0;
  logic [DQ_W-1:0] wdata_in = '0;
  logic [3:0] cmd_o;
  logic [BA_W-1:0] ba_o;
  logic [ADDR_W-1:0] addr_o;
  logic [DQ_W-1:0] dq_o;
  logic dq_oe_o, dqm_o, busy_o;
  logic [NB-1:0] bank_rdy_o;

  int total = 0;
  int bad = 0;
  int seq = 0;

  always #2.5 clk = ~clk;

  wr_term_seq #(.NB(NB), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(10), .DQ_W(DQ_W),
                .TWR(TWR), .TRP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .late_pre(late_pre), .req_valid(req_valid),
    .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_stop(req_stop),
    .req_follow(req_follow), .req_ap(req_ap), .req_rd_col(req_rd_col),
    .term_rd(term_rd), .term_pre(term_pre), .wdata_in(wdata_in),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .dqm_o(dqm_o), .busy_o(busy_o), .bank_rdy_o(bank_rdy_o)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (case %0d)", tag, what, act, exp, seq);
    end
  endtask

  // term_kind: 0 none, 1 read, 2 precharge; poke: 1 request while busy, 2 request to recovering bank
  task automatic run_case(input int bank, input int col, input int len, input int stop,
                          input int fol, input int ap, input int late, input int rdcol,
                          input int term_at, input int term_kind, input int poke);
    int blen, n, last, act, p, fin, hold;
    bit page;
    logic [3:0] ecmd;
    string ctag;
    seq++;
    blen = (len == 0) ? 2 : (len == 1) ? 4 : (len == 2) ? 8 : (1 << COL_W);
    page = (len == 3);
    if (stop != 0) n = (stop < blen) ? stop : blen;
    else           n = page ? -1 : blen;
    last = (term_kind != 0) ? term_at : n - 1;
    if (term_kind == 1)      act = 1;
    else if (term_kind == 2) act = ap ? 0 : 2;
    else                     act = (fol == 1) ? 1 : (fol == 2 && ap == 0) ? 2 : 0;
    hold = ((TWR == 0) ? 1 : TWR) + TRP;
    p = last + 1 + TWR + late;
    fin = (act == 2) ? p + TRP + 3 : (ap != 0 ? last + hold + 3 : last + 4);
    @(negedge clk);
    req_bank = BA_W'(bank); req_col = COL_W'(col); req_len = 2'(len);
    req_stop = (COL_W+1)'(stop); req_follow = 2'(fol); req_ap = (ap != 0);
    req_rd_col = COL_W'(rdcol); late_pre = (late != 0); req_valid = 1'b1;
    @(negedge clk);
    for (int k = 0; k <= fin; k++) begin
      wdata_in = DQ_W'(k * 293 + bank * 17 + 5);
      term_rd  = (term_kind == 1 && k == term_at);
      term_pre = (term_kind == 2 && k == term_at);
      if (poke == 1 && k == 1) begin
        req_valid = 1'b1; req_bank = BA_W'(bank ^ 1);
      end else if (poke == 2 && k == p + 1) begin
        req_valid = 1'b1; req_bank = BA_W'(bank);
      end else begin
        req_valid = 1'b0;
      end
      #1;
      ecmd = E_NOP; ctag = "R10";
      if (k == 0) begin ecmd = E_WR; ctag = "R2"; end
      else if (act == 1 && k == last + 1) begin ecmd = E_RD; ctag = "R4"; end
      else if (act == 2 && k == p) begin ecmd = E_PRE; ctag = "R5"; end
      chk(cmd_o == ecmd, ctag, "cmd", cmd_o, ecmd);
      if (ecmd != E_NOP) chk(ba_o == BA_W'(bank), ctag, "bank", ba_o, bank);
      if (ecmd == E_WR)  chk(addr_o == ADDR_W'(col | (ap << 10)), "R2", "addr", addr_o, col | (ap << 10));
      if (ecmd == E_RD)  chk(addr_o == ADDR_W'(rdcol), "R4", "addr", addr_o, rdcol);
      if (ecmd == E_PRE) chk(addr_o[10] == 1'b0, "R5", "a10", addr_o[10], 0);
      chk(dq_oe_o == (k <= last), page ? "R9" : "R3", "dq_oe", dq_oe_o, (k <= last));
      if (k <= last) chk(dq_o == wdata_in, "R3", "dq", dq_o, wdata_in);
      chk(dqm_o == (act == 2 && k > last && k <= p), "R6", "dqm", dqm_o,
          (act == 2 && k > last && k <= p));
      if (act == 2)
        chk(bank_rdy_o[bank] == !(k >= p + 1 && k <= p + TRP), "R7", "bank_rdy",
            bank_rdy_o[bank], !(k >= p + 1 && k <= p + TRP));
      else if (ap != 0 && act == 0)
        chk(bank_rdy_o[bank] == !(k >= last + 1 && k <= last + hold), "R8", "bank_rdy",
            bank_rdy_o[bank], !(k >= last + 1 && k <= last + hold));
      @(negedge clk);
    end
    term_rd = 1'b0; term_pre = 1'b0; req_valid = 1'b0;
    #1;
    chk(busy_o == 1'b0, "R10", "busy at end", busy_o, 0);
  endtask

  initial begin : main
    int stops[3];
    int c;
    stops[0] = 0; stops[1] = 1; stops[2] = 3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(cmd_o == E_NOP, "R1", "cmd", cmd_o, E_NOP);
    chk(dqm_o == 1'b0, "R1", "dqm", dqm_o, 0);
    chk(dq_oe_o == 1'b0, "R1", "dq_oe", dq_oe_o, 0);
    chk(busy_o == 1'b0, "R1", "busy", busy_o, 0);
    chk(bank_rdy_o == '1, "R1", "bank_rdy", bank_rdy_o, 4'hf);
    c = 0;
    for (int len = 0; len < 3; len++)
      for (int si = 0; si < 3; si++)
        for (int fol = 0; fol < 3; fol++)
          for (int ap = 0; ap < 2; ap++)
            for (int late = 0; late < 2; late++) begin
              run_case(c % NB, (c * 7) % 256, len, stops[si], fol, ap, late, (c * 11) % 256,
                       -1, 0, 0);
              c++;
            end
    // R4: fixed burst of eight cut by a read after beat 2
    run_case(1, 40, 2, 0, 0, 0, 0, 99, 2, 1, 0);
    // R9: page burst ended by read at beat 5
    run_case(2, 200, 3, 0, 0, 0, 0, 17, 5, 1, 0);
    // R9 R5: page burst ended by precharge at beat 12, late variant, overriding a read follow
    run_case(3, 3, 3, 0, 1, 0, 1, 8, 12, 2, 0);
    // R9: page burst with a count of 20 and precharge follow
    run_case(0, 128, 3, 20, 2, 0, 0, 0, -1, 0, 0);
    // R8: page burst with auto precharge, term_pre dropped
    run_case(1, 9, 3, 0, 2, 1, 0, 0, 3, 2, 0);
    // R10: request while busy is ignored
    run_case(2, 50, 1, 0, 1, 0, 0, 77, -1, 0, 1);
    // R7: request to a recovering bank is ignored
    run_case(3, 60, 1, 0, 2, 0, 0, 0, -1, 0, 2);
    run_case(0, 61, 1, 2, 2, 0, 1, 0, -1, 0, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule